// File: doc/BRIEF.md
# SD Host Data-Control Register Unit

This unit holds the data-transfer control word of an SD/MMC host controller. Firmware writes and reads it through a simple register port. Each field follows its own rule for when a write is taken and when hardware clears it. The unit watches the status of the data-path state machine: its active flag, its current state, transfer completion, error or hold, and whether DMA is enabled. From these it drives the decoded control outputs that the data path consumes.

Besides storing fields, the unit decodes the 4-bit block-size code into a block length in bytes. It also turns a programmed data length into the number of bytes that will actually move. In block modes that count is truncated to whole blocks. It is forced to zero for combinations that would move no data. A FIFO-flush request from firmware becomes a single-cycle pulse toward the FIFO, but only when the request can act. The data-path state machine, the FIFO and the card bus are outside this unit.

All pins are plain control and status signals, with no streaming data. A write is one cycle with `wr_en` high and is never stalled. A read is combinational from the stored fields.

Top module: `sdh_dctl_unit`

## Requirements
- R1: After reset every field is zero. `rd_data` returns the fields at these positions: bit 0 enable, bit 1 direction, bits 3:2 mode, bits 7:4 block-size code, bit 8 read-wait start, bit 9 read-wait stop, bit 10 read-wait mode, bit 11 SDIO interrupt enable, bit 12 boot-ack enable, bit 13 FIFO reset. Bits 31:14 read as zero.
- R2: A write updates enable, direction, mode, block-size code, read-wait mode, SDIO enable and boot-ack enable only while `dp_active` is 0. While `dp_active` is 1 these fields keep their values. The stored values appear on the matching outputs. Read-wait mode 0 means signalling on data line 2, and 1 means stopping the card clock.
- R3: `xfer_done` clears the enable bit at the next edge. The clear wins over a write in the same cycle.
- R4: A block-size code n from 0 to 14 gives `blk_bytes` = 2^n with `cfg_err` = 0. Code 15 gives `blk_bytes` = 0 and `cfg_err` = 1.
- R5: In mode 0 (block, ends on count) and mode 3 (block, ends on stop command), `xfer_bytes` is `data_len` rounded down to a multiple of `blk_bytes`, or 0 for code 15. In mode 1 (SDIO multibyte) and mode 2 (stream), `xfer_bytes` equals `data_len`.
- R6: In a block mode, with `ddr_en` = 1 and block-size code 0, `xfer_bytes` is 0.
- R7: Read-wait start and read-wait stop take every write, whatever the value of `dp_active`. Read-wait stop is cleared at the edge where `dp_state` has moved from read-wait (4) to wait-receive (2) or idle (0), and the clear wins over a write. A move from read-wait to any other state leaves it set.
- R8: The FIFO-reset bit takes a write only when `dma_en` = 0 and `dp_active` = 1. It is cleared at every edge where `dp_active` = 0.
- R9: `fifo_flush` is high for exactly the one cycle after an accepted write that sets the FIFO-reset bit while `xfer_err` or `xfer_hold` is 1. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| dp_active | input | 1 | Data path is active |
| dp_state | input | 3 | Data path state (0 idle, 2 wait-receive, 4 read-wait) |
| xfer_done | input | 1 | Transfer completed |
| xfer_err | input | 1 | Transfer error present |
| xfer_hold | input | 1 | Transfer hold present |
| dma_en | input | 1 | DMA enabled |
| ddr_en | input | 1 | Double-data-rate mode |
| data_len | input | 25 | Programmed data length in bytes |
| xfer_en | output | 1 | Transfer enable |
| xfer_dir | output | 1 | Direction (1 = card to host) |
| xfer_mode | output | 2 | Transfer mode |
| blk_bytes | output | 16 | Decoded block length in bytes |
| xfer_bytes | output | 25 | Effective transfer byte count |
| cfg_err | output | 1 | Reserved block-size code selected |
| rw_start | output | 1 | Read-wait start |
| rw_stop | output | 1 | Read-wait stop |
| rw_mode | output | 1 | Read-wait method |
| sdio_irq_en | output | 1 | SDIO interrupt enable |
| bootack_en | output | 1 | Boot acknowledgment expected |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |

## Verification
Some rules are checked on every cycle. Gated fields must hold while the data path is active. Enable must be cleared after completion, and read-wait stop must be cleared after leaving read-wait toward wait-receive or idle. The FIFO-reset bit must be clear after an inactive cycle. Every flush pulse must trace back to an accepted write. The decoded length must be a single power of two or zero, and the effective count may never exceed the data length.

Other results need the bench's scenarios. These include the exact truncated byte counts across every mode, code and DDR setting, and the priority of hardware clears over simultaneous writes. They also include the transitions out of read-wait that must not clear the stop bit, and the DMA and error conditions under which no flush may occur.

// File: rtl/sdh_dctl_pkg.sv
package sdh_dctl_pkg;
  localparam int REG_W  = 32;
  localparam int CODE_W = 4;
  localparam int ST_W   = 3;
  localparam int FLD_W  = 14;

  localparam logic [ST_W-1:0]   ST_IDLE  = 3'd0;
  localparam logic [ST_W-1:0]   ST_WAITR = 3'd2;
  localparam logic [ST_W-1:0]   ST_RW    = 3'd4;
  localparam logic [CODE_W-1:0] CODE_RSV = 4'hF;

  typedef enum logic [1:0] {
    MODE_BLK_CNT  = 2'd0,
    MODE_SDIO     = 2'd1,
    MODE_STREAM   = 2'd2,
    MODE_BLK_STOP = 2'd3
  } xfer_mode_e;

  // Field layout, msb first; matches the read-back bit positions.
  typedef struct packed {
    logic              fifo_rst;
    logic              bootack;
    logic              sdio;
    logic              rw_mode;
    logic              rw_stop;
    logic              rw_start;
    logic [CODE_W-1:0] code;
    xfer_mode_e        mode;
    logic              dir;
    logic              en;
  } dctl_t;
endpackage

// File: rtl/sdh_dctl_regs.sv
module sdh_dctl_regs
  import sdh_dctl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [REG_W-1:0]       wr_data,
  input  logic                   dp_active,
  input  logic [ST_W-1:0]        dp_state,
  input  logic                   xfer_done,
  input  logic                   dma_en,
  output dctl_t                  fld,
  output logic                   fifo_set_acc
);
  dctl_t            wv;
  logic [ST_W-1:0]  prev_q;
  logic             cfg_wr;
  logic             fifo_wr;
  logic             rw_leave;

  assign wv       = dctl_t'(wr_data[FLD_W-1:0]);
  assign cfg_wr   = wr_en && !dp_active;
  assign fifo_wr  = wr_en && dp_active && !dma_en;
  assign rw_leave = (prev_q == ST_RW) &&
                    ((dp_state == ST_WAITR) || (dp_state == ST_IDLE));
  assign fifo_set_acc = fifo_wr && wv.fifo_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld    <= '0;
      prev_q <= ST_IDLE;
    end else begin
      prev_q <= dp_state;
      if (cfg_wr) begin
        fld.en      <= wv.en;
        fld.dir     <= wv.dir;
        fld.mode    <= wv.mode;
        fld.code    <= wv.code;
        fld.rw_mode <= wv.rw_mode;
        fld.sdio    <= wv.sdio;
        fld.bootack <= wv.bootack;
      end
      if (wr_en) begin
        fld.rw_start <= wv.rw_start;
        fld.rw_stop  <= wv.rw_stop;
      end
      if (rw_leave)   fld.rw_stop  <= 1'b0;
      if (fifo_wr)    fld.fifo_rst <= wv.fifo_rst;
      if (!dp_active) fld.fifo_rst <= 1'b0;
      if (xfer_done)  fld.en       <= 1'b0;
    end
  end

  // R2
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_active |=> $stable({fld.dir, fld.mode, fld.code, fld.rw_mode, fld.sdio, fld.bootack}));
  // R3
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !fld.en);
  // R7
  rwstop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((prev_q == ST_RW) && ((dp_state == ST_WAITR) || (dp_state == ST_IDLE))) |=> !fld.rw_stop);
  // R8
  fifo_inact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_active |=> !fld.fifo_rst);
endmodule

// File: rtl/sdh_dctl_len.sv
module sdh_dctl_len
  import sdh_dctl_pkg::*;
#(
  parameter int DLEN_W = 25,
  parameter int BLK_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  xfer_mode_e        mode,
  input  logic              ddr_en,
  input  logic [DLEN_W-1:0] data_len,
  output logic [BLK_W-1:0]  blk_bytes,
  output logic [DLEN_W-1:0] xfer_bytes,
  output logic              cfg_err
);
  localparam int NCODE = (1 << CODE_W) - 1;

  logic [DLEN_W-1:0] keep_mask;
  logic [DLEN_W-1:0] trunc_len;
  logic              is_blk;
  logic              zero_len;

  assign cfg_err = (code == CODE_RSV);

  for (genvar i = 0; i < BLK_W; i++) begin : g_dec
    if (i < NCODE) begin : g_valid
      assign blk_bytes[i] = (code == CODE_W'(i));
    end else begin : g_rsv
      assign blk_bytes[i] = 1'b0;
    end
  end

  assign keep_mask = {DLEN_W{1'b1}} << code;
  assign trunc_len = data_len & keep_mask;
  assign is_blk    = (mode == MODE_BLK_CNT) || (mode == MODE_BLK_STOP);
  assign zero_len  = cfg_err || (ddr_en && (code == '0));

  always_comb begin
    if (!is_blk)       xfer_bytes = data_len;
    else if (zero_len) xfer_bytes = '0;
    else               xfer_bytes = trunc_len;
  end

  // R4
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (blk_bytes == '0));
  // R4
  blk_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err |-> ($countones(blk_bytes) == 1));
  // R5
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_bytes <= data_len);
endmodule

// File: rtl/sdh_dctl_flush.sv
module sdh_dctl_flush (
  input  logic clk,
  input  logic rst_n,
  input  logic set_acc,
  input  logic xfer_err,
  input  logic xfer_hold,
  output logic fifo_flush
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_flush <= 1'b0;
    else        fifo_flush <= set_acc && (xfer_err || xfer_hold);
  end

  // R9
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> $past(xfer_err || xfer_hold));
endmodule

// File: rtl/sdh_dctl_unit.sv
module sdh_dctl_unit
  import sdh_dctl_pkg::*;
#(
  parameter int DLEN_W = 25,
  parameter int BLK_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              dp_active,
  input  logic [2:0]        dp_state,
  input  logic              xfer_done,
  input  logic              xfer_err,
  input  logic              xfer_hold,
  input  logic              dma_en,
  input  logic              ddr_en,
  input  logic [DLEN_W-1:0] data_len,
  output logic              xfer_en,
  output logic              xfer_dir,
  output logic [1:0]        xfer_mode,
  output logic [BLK_W-1:0]  blk_bytes,
  output logic [DLEN_W-1:0] xfer_bytes,
  output logic              cfg_err,
  output logic              rw_start,
  output logic              rw_stop,
  output logic              rw_mode,
  output logic              sdio_irq_en,
  output logic              bootack_en,
  output logic              fifo_flush
);
  dctl_t fld;
  logic  fifo_set_acc;

  sdh_dctl_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .dp_active    (dp_active),
    .dp_state     (dp_state),
    .xfer_done    (xfer_done),
    .dma_en       (dma_en),
    .fld          (fld),
    .fifo_set_acc (fifo_set_acc)
  );

  sdh_dctl_len #(.DLEN_W(DLEN_W), .BLK_W(BLK_W)) u_len (
    .clk        (clk),
    .rst_n      (rst_n),
    .code       (fld.code),
    .mode       (fld.mode),
    .ddr_en     (ddr_en),
    .data_len   (data_len),
    .blk_bytes  (blk_bytes),
    .xfer_bytes (xfer_bytes),
    .cfg_err    (cfg_err)
  );

  sdh_dctl_flush u_flush (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_acc    (fifo_set_acc),
    .xfer_err   (xfer_err),
    .xfer_hold  (xfer_hold),
    .fifo_flush (fifo_flush)
  );

  assign rd_data     = {{(REG_W-FLD_W){1'b0}}, fld};
  assign xfer_en     = fld.en;
  assign xfer_dir    = fld.dir;
  assign xfer_mode   = fld.mode;
  assign rw_start    = fld.rw_start;
  assign rw_stop     = fld.rw_stop;
  assign rw_mode     = fld.rw_mode;
  assign sdio_irq_en = fld.sdio;
  assign bootack_en  = fld.bootack;

  // R9
  flush_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> $past(wr_en && wr_data[13] && dp_active && !dma_en));
  // R1
  rd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:14] == '0);
endmodule

// File: tb/sdh_dctl_unit_tb.sv
module sdh_dctl_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLW = 25;
  localparam int BW  = 16;
  localparam int WDOG = 100000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [31:0]    wr_data;
  logic [31:0]    rd_data;
  logic           dp_active;
  logic [2:0]     dp_state;
  logic           xfer_done, xfer_err, xfer_hold, dma_en, ddr_en;
  logic [DLW-1:0] data_len;
  logic           xfer_en, xfer_dir, cfg_err;
  logic [1:0]     xfer_mode;
  logic [BW-1:0]  blk_bytes;
  logic [DLW-1:0] xfer_bytes;
  logic           rw_start, rw_stop, rw_mode, sdio_irq_en, bootack_en, fifo_flush;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_dctl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dp_active(dp_active), .dp_state(dp_state), .xfer_done(xfer_done),
    .xfer_err(xfer_err), .xfer_hold(xfer_hold), .dma_en(dma_en), .ddr_en(ddr_en),
    .data_len(data_len), .xfer_en(xfer_en), .xfer_dir(xfer_dir), .xfer_mode(xfer_mode),
    .blk_bytes(blk_bytes), .xfer_bytes(xfer_bytes), .cfg_err(cfg_err),
    .rw_start(rw_start), .rw_stop(rw_stop), .rw_mode(rw_mode),
    .sdio_irq_en(sdio_irq_en), .bootack_en(bootack_en), .fifo_flush(fifo_flush)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_xb(input int mode, input int code, input int ddr, input int dl);
    if (mode == 1 || mode == 2) return 32'(dl);
    if (code == 15 || (ddr == 1 && code == 0)) return 0;
    return 32'(dl - (dl % (1 << code)));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens[5];
    lens[0] = 0; lens[1] = 1; lens[2] = 1000; lens[3] = 16383; lens[4] = 25'h1ABCDEF;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; dp_active = 1'b0; dp_state = 3'd0;
    xfer_done = 1'b0; xfer_err = 1'b0; xfer_hold = 1'b0; dma_en = 1'b0; ddr_en = 1'b0;
    data_len = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    check("R1 rd_data reset", rd_data, 32'h0);
    check("R1 outputs reset", {xfer_en, xfer_dir, xfer_mode, rw_start, rw_stop, rw_mode,
                               sdio_irq_en, bootack_en, fifo_flush}, 0);

    // R2 write while inactive, then ignored while active
    wr(32'hFFFF_DC5F);
    check("R2 inactive write / R1 pad", rd_data, 32'h0000_1C5F);
    check("R2 outputs", {xfer_en, xfer_dir, xfer_mode, rw_mode, sdio_irq_en, bootack_en}, 8'b1111_111);
    check("R4 code5", blk_bytes, 32);
    dp_active = 1'b1;
    wr(32'h0);
    check("R2 active write ignored", rd_data, 32'h0000_1C5F);

    // R3 completion clears enable
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    check("R3 done clears en", rd_data, 32'h0000_1C5E);
    dp_active = 1'b0;
    @(negedge clk); xfer_done = 1'b1; wr_en = 1'b1; wr_data = 32'h1;
    @(negedge clk); xfer_done = 1'b0; wr_en = 1'b0;
    check("R3 clear beats write", xfer_en, 0);
    wr(32'h1);
    check("R3 en set inactive", xfer_en, 1);

    // R7 read-wait stop
    dp_active = 1'b1;
    wr(32'h300);
    check("R7 rw bits write while active", {rw_start, rw_stop}, 2'b11);
    check("R7 gated fields untouched", rd_data, 32'h0000_0301);
    @(negedge clk); dp_state = 3'd4;
    @(negedge clk); dp_state = 3'd1;
    step();
    check("R7 RW->1 keeps stop", rw_stop, 1);
    wr(32'h200); @(negedge clk); dp_state = 3'd4;
    @(negedge clk); dp_state = 3'd2;
    step();
    check("R7 RW->waitr clears", rw_stop, 0);
    wr(32'h200); @(negedge clk); dp_state = 3'd4;
    @(negedge clk); dp_state = 3'd0;
    step();
    check("R7 RW->idle clears", rw_stop, 0);
    @(negedge clk); dp_state = 3'd4;
    @(negedge clk); dp_state = 3'd0; wr_en = 1'b1; wr_data = 32'h200;
    @(negedge clk); wr_en = 1'b0;
    check("R7 clear beats write", rw_stop, 0);
    dp_active = 1'b0;
    wr(32'h200);
    check("R7 write while inactive", rw_stop, 1);
    wr(32'h0);

    // R8 / R9 FIFO reset and flush
    dp_active = 1'b1; dma_en = 1'b1; xfer_err = 1'b1;
    wr(32'h2000);
    check("R8 dma blocks write", rd_data[13], 0);
    check("R9 no flush with dma", fifo_flush, 0);
    dma_en = 1'b0; xfer_err = 1'b0;
    wr(32'h2000);
    check("R8 write accepted", rd_data[13], 1);
    check("R9 no flush without err/hold", fifo_flush, 0);
    xfer_err = 1'b1;
    wr(32'h2000);
    check("R9 flush on err", fifo_flush, 1);
    step();
    check("R9 flush one cycle", fifo_flush, 0);
    xfer_err = 1'b0; xfer_hold = 1'b1;
    wr(32'h2000);
    check("R9 flush on hold", fifo_flush, 1);
    step();
    check("R9 flush one cycle hold", fifo_flush, 0);
    xfer_hold = 1'b0;
    dp_active = 1'b0;
    step();
    check("R8 cleared inactive", rd_data[13], 0);
    xfer_err = 1'b1;
    wr(32'h2000);
    check("R8 inactive write ignored", rd_data[13], 0);
    check("R9 no flush inactive", fifo_flush, 0);
    xfer_err = 1'b0;

    // R4 R5 R6 sweep over mode, code, ddr, length
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 16; c++) begin
        wr(32'((m << 2) | (c << 4)));
        check("R4 blk_bytes", blk_bytes, (c == 15) ? 0 : (1 << c));
        check("R4 cfg_err", cfg_err, (c == 15) ? 1 : 0);
        for (int d = 0; d < 2; d++) begin
          for (int k = 0; k < 5; k++) begin
            @(negedge clk); ddr_en = d[0]; data_len = DLW'(lens[k]);
            #1;
            if (d == 1 && c == 0 && (m == 0 || m == 3))
              check("R6 ddr code0 zero", xfer_bytes, 0);
            else
              check("R5 xfer_bytes", xfer_bytes, exp_xb(m, c, d, lens[k]));
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule